// File: doc/BRIEF.md
# Reference Clock Ratio Detector

This block decides, purely by measurement, how an incoming reference clock relates to a fast oscillator-side clock. The oscillator runs at 16, 32 or 128 times the reference. No strap or configuration input selects the ratio. The block also reports whether the reference is toggling at all, so that downstream loss-of-lock logic can force its alarm when the reference is missing.

A counter in the reference domain counts reference edges without stopping. In the fast domain, a window timer of `WIN_CYCLES` fast cycles asks for a snapshot of that counter through a toggle request/acknowledge pair. The difference between two snapshots gives the edge count for one window. That count is compared against three bands centred on `WIN_CYCLES/16`, `WIN_CYCLES/32` and `WIN_CYCLES/128`, each band ±1/`TOL_DIV` wide. A filter then turns the per-window verdicts into a stable ratio code. Evaluation never stops, so a later change of reference frequency is followed.

If a snapshot request is still unanswered when the next window ends, the reference is taken to be absent. The first answered snapshot after an absence, or after reset, only sets a new baseline. It is not evaluated.

Top module: `refclk_ratio_detect`

## Requirements
- R1: While reset is active and just after it, `ref_active` is 0, `ratio_code` is 2'b11 (undetermined) and `ratio_invalid` is 0.
- R2: With a reference at 1/16 of the fast clock, `ratio_code` settles to 2'b00, with `ref_active`=1 and `ratio_invalid`=0.
- R3: With a reference at 1/32 of the fast clock, `ratio_code` settles to 2'b01, with `ref_active`=1 and `ratio_invalid`=0.
- R4: With a reference at 1/128 of the fast clock, `ratio_code` settles to 2'b10, with `ref_active`=1 and `ratio_invalid`=0.
- R5: A window in which no reference edge is seen (a count of zero or an unanswered snapshot request) drives `ref_active` to 0 and `ratio_code` to 2'b11 one cycle after that window's evaluation.
- R6: A nonzero count outside all three bands keeps the previous `ratio_code`, sets `ratio_invalid` to 1 and keeps `ref_active` at 1. The next in-band window clears `ratio_invalid`.
- R7: `ratio_code` takes a new value only after two consecutive evaluated windows classify to that same ratio. A single window with a different ratio leaves the code unchanged.
- R8: The outputs change only in the cycle after a window evaluation. Evaluation repeats every window for as long as the block runs, so a later change of reference ratio is followed.
- R9: Whenever `ref_active` is 0, `ratio_code` is 2'b11, and `ratio_invalid` is never 1 while `ref_active` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock at the oscillator rate; times the measurement window |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ref_clk | input | 1 | Reference clock being measured |
| ref_active | output | 1 | 1 while reference edges are being seen |
| ratio_code | output | 2 | 00 = x16, 01 = x32, 10 = x128, 11 = undetermined |
| ratio_invalid | output | 1 | 1 when the last evaluated count fell outside every band |

## Verification
Each window ends every `WIN_CYCLES` fast cycles. Its verdict reaches the outputs one cycle later. The count itself lags the window by the request and acknowledge synchronisers, a few reference periods plus two fast cycles. A ratio change therefore shows on `ratio_code` within three windows, a loss of reference within two windows, and a return of the reference within four, because the first snapshot after the return only sets a baseline. The bench counts phases in whole windows from the release of reset. It waits out the settling interval that applies to each change, then compares all three outputs against its model on every fast-clock cycle of the following windows. In the single-window glitch phase the comparison starts at the glitch itself, so any brief switch would be seen.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
package rcd_pkg;

   typedef enum logic [1:0] {
      RC_DIV16  = 2'b00,
      RC_DIV32  = 2'b01,
      RC_DIV128 = 2'b10,
      RC_NONE   = 2'b11
   } ratio_code_e;

   localparam int unsigned N_RATIOS = 3;

   // oscillator-to-reference ratio for band index
   function automatic int unsigned ratio_of(input int unsigned idx);
      case (idx)
         0:       return 16;
         1:       return 32;
         default: return 128;
      endcase
   endfunction

   function automatic ratio_code_e code_of(input int unsigned idx);
      case (idx)
         0:       return RC_DIV16;
         1:       return RC_DIV32;
         default: return RC_DIV128;
      endcase
   endfunction

endpackage

// File: rtl/rcd_sync.sv
`timescale 1ns/1ps
module rcd_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[gs] <= '0;
            else        chain[gs] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[gs] <= '0;
            else        chain[gs] <= chain[gs-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rcd_ref_counter.sv
`timescale 1ns/1ps
module rcd_ref_counter #(
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             req_tgl,
   output logic [CNT_W-1:0] hold_cnt,
   output logic             ack_tgl
);
   logic             req_s;
   logic [CNT_W-1:0] edge_cnt;

   rcd_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (req_tgl),
      .q     (req_s)
   );

   // free-running edge counter, wraps modulo 2^CNT_W
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) edge_cnt <= '0;
      else        edge_cnt <= edge_cnt + 1'b1;
   end

   // snapshot on each request toggle, then answer with the same level
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         ack_tgl  <= 1'b0;
      end else if (req_s != ack_tgl) begin
         hold_cnt <= edge_cnt;
         ack_tgl  <= req_s;
      end
   end
endmodule

// File: rtl/rcd_window.sv
`timescale 1ns/1ps
module rcd_window #(
   parameter int WIN_CYCLES  = 2048,
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] hold_cnt,
   input  logic             ack_tgl,
   output logic             req_tgl,
   output logic             res_valid,
   output logic [CNT_W-1:0] res_count
);
   localparam int WIN_W = $clog2(WIN_CYCLES);
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

   logic [WIN_W-1:0] win_cnt;
   logic             win_end;
   logic             ack_s, ack_seen, ack_new;
   logic             fresh, stale;
   logic [CNT_W-1:0] snap, base;

   rcd_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_tgl),
      .q     (ack_s)
   );

   assign win_end = (win_cnt == WIN_LAST);
   assign ack_new = (ack_s != ack_seen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       win_cnt <= '0;
      else if (win_end) win_cnt <= '0;
      else              win_cnt <= win_cnt + 1'b1;
   end

   // capture the held count once its acknowledge has crossed over
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_seen <= 1'b0;
         snap     <= '0;
      end else if (ack_new) begin
         ack_seen <= ack_s;
         snap     <= hold_cnt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fresh <= 1'b0;
      else if (win_end) fresh <= ack_new;
      else if (ack_new) fresh <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tgl   <= 1'b0;
         res_valid <= 1'b0;
         res_count <= '0;
         base      <= '0;
         stale     <= 1'b1;
      end else begin
         res_valid <= 1'b0;
         if (win_end) begin
            if (req_tgl != ack_seen) begin
               // request still unanswered: no reference activity
               res_valid <= 1'b1;
               res_count <= '0;
               stale     <= 1'b1;
            end else begin
               req_tgl <= ~req_tgl;
               if (stale) begin
                  if (fresh) begin
                     base  <= snap;
                     stale <= 1'b0;
                  end
               end else begin
                  res_valid <= 1'b1;
                  res_count <= snap - base;
                  base      <= snap;
               end
            end
         end
      end
   end
endmodule

// File: rtl/rcd_classifier.sv
`timescale 1ns/1ps
module rcd_classifier #(
   parameter int WIN_CYCLES = 2048,
   parameter int CNT_W      = 12,
   parameter int TOL_DIV    = 4
) (
   input  logic               [CNT_W-1:0] count,
   output logic                           hit,
   output rcd_pkg::ratio_code_e           code
);
   import rcd_pkg::*;

   logic [N_RATIOS-1:0] in_band;

   for (genvar gb = 0; gb < N_RATIOS; gb++) begin : g_band
      localparam int unsigned EXP = WIN_CYCLES / ratio_of(gb);
      localparam int unsigned LO  = EXP - EXP / TOL_DIV;
      localparam int unsigned HI  = EXP + EXP / TOL_DIV;
      assign in_band[gb] = (count >= CNT_W'(LO)) && (count <= CNT_W'(HI));
   end

   assign hit = |in_band;

   always_comb begin
      code = RC_NONE;
      for (int i = N_RATIOS - 1; i >= 0; i--) begin
         if (in_band[i]) code = code_of(i);
      end
   end
endmodule

// File: rtl/rcd_decision.sv
`timescale 1ns/1ps
module rcd_decision (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 res_valid,
   input  logic                 cnt_zero,
   input  logic                 v_hit,
   input  rcd_pkg::ratio_code_e v_code,
   output logic                 active_q,
   output rcd_pkg::ratio_code_e code_q,
   output logic                 invalid_q
);
   import rcd_pkg::*;

   ratio_code_e cand_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         code_q    <= RC_NONE;
         invalid_q <= 1'b0;
         cand_q    <= RC_NONE;
      end else if (res_valid) begin
         if (cnt_zero) begin
            active_q  <= 1'b0;
            code_q    <= RC_NONE;
            invalid_q <= 1'b0;
            cand_q    <= RC_NONE;
         end else if (!v_hit) begin
            active_q  <= 1'b1;
            invalid_q <= 1'b1;
            cand_q    <= RC_NONE;
         end else begin
            active_q  <= 1'b1;
            invalid_q <= 1'b0;
            cand_q    <= v_code;
            if (v_code == cand_q) code_q <= v_code;
         end
      end
   end
endmodule

// File: rtl/refclk_ratio_detect.sv
`timescale 1ns/1ps
module refclk_ratio_detect #(
   parameter int WIN_CYCLES  = 2048,
   parameter int TOL_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_fast,
   input  logic       rst_n,
   input  logic       ref_clk,
   output logic       ref_active,
   output logic [1:0] ratio_code,
   output logic       ratio_invalid
);
   import rcd_pkg::*;

   localparam int CNT_W = $clog2(WIN_CYCLES) + 1;

   if (WIN_CYCLES % 128 != 0 || WIN_CYCLES < 256) begin : g_bad_win
      $error("WIN_CYCLES must be a multiple of 128 and at least 256");
   end
   if (TOL_DIV < 4) begin : g_bad_tol
      $error("TOL_DIV below 4 lets neighbouring bands overlap");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             req_tgl, ack_tgl;
   logic [CNT_W-1:0] hold_cnt, res_count;
   logic             res_valid, cnt_zero, v_hit;
   ratio_code_e      v_code, code_q;

   rcd_ref_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_refcnt (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .req_tgl  (req_tgl),
      .hold_cnt (hold_cnt),
      .ack_tgl  (ack_tgl)
   );

   rcd_window #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_win (
      .clk       (clk_fast),
      .rst_n     (rst_n),
      .hold_cnt  (hold_cnt),
      .ack_tgl   (ack_tgl),
      .req_tgl   (req_tgl),
      .res_valid (res_valid),
      .res_count (res_count)
   );

   assign cnt_zero = (res_count == '0);

   rcd_classifier #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W), .TOL_DIV(TOL_DIV)) u_cls (
      .count (res_count),
      .hit   (v_hit),
      .code  (v_code)
   );

   rcd_decision u_dec (
      .clk       (clk_fast),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .cnt_zero  (cnt_zero),
      .v_hit     (v_hit),
      .v_code    (v_code),
      .active_q  (ref_active),
      .code_q    (code_q),
      .invalid_q (ratio_invalid)
   );

   assign ratio_code = code_q;
endmodule

// File: rtl/rcd_checker.sv
`timescale 1ns/1ps
module rcd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       res_valid,
   input logic       cnt_zero,
   input logic       v_hit,
   input logic [1:0] v_code,
   input logic       ref_active,
   input logic [1:0] ratio_code,
   input logic       ratio_invalid
);
   logic [1:0] w_last, w_prev;

   // verdict history of the last two evaluated windows (11 = no ratio)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_last <= 2'b11;
         w_prev <= 2'b11;
      end else if (res_valid) begin
         w_prev <= w_last;
         w_last <= (cnt_zero || !v_hit) ? 2'b11 : v_code;
      end
   end

   p_zero_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && cnt_zero) |=> (!ref_active && ratio_code == 2'b11));

   p_oob_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !cnt_zero && !v_hit) |=> (ratio_invalid && ref_active && $stable(ratio_code)));

   p_two_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(ratio_code) && ratio_code != 2'b11) |-> (w_last == ratio_code && w_prev == ratio_code));

   p_quiet_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> ($stable(ratio_code) && $stable(ref_active) && $stable(ratio_invalid)));

   p_idle_undetermined_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_active |-> (ratio_code == 2'b11 && !ratio_invalid));
endmodule

bind refclk_ratio_detect rcd_checker u_chk (
   .clk           (clk_fast),
   .rst_n         (rst_n),
   .res_valid     (res_valid),
   .cnt_zero      (cnt_zero),
   .v_hit         (v_hit),
   .v_code        (v_code),
   .ref_active    (ref_active),
   .ratio_code    (ratio_code),
   .ratio_invalid (ratio_invalid)
);

// File: tb/refclk_ratio_detect_bench.sv
`timescale 1ns/1ps
module refclk_ratio_detect_bench;
   localparam int WIN = 2048;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_clk;
   logic       ref_active, ratio_invalid;
   logic [1:0] ratio_code;

   int ref_ratio = 0;   // 0 = reference stopped
   int n_tests = 0;
   int n_fail  = 0;
   int n_print = 0;
   bit done = 1'b0;

   refclk_ratio_detect #(.WIN_CYCLES(WIN)) u_refclk_ratio_detect (
      .clk_fast      (clk),
      .rst_n         (rst_n),
      .ref_clk       (ref_clk),
      .ref_active    (ref_active),
      .ratio_code    (ratio_code),
      .ratio_invalid (ratio_invalid)
   );

   always #4 clk = ~clk;

   // reference source: period = ratio * 8 ns
   initial begin
      ref_clk = 1'b0;
      forever begin
         if (ref_ratio == 0) begin
            ref_clk = 1'b0;
            #8;
         end else begin
            #(ref_ratio * 4);
            ref_clk = ~ref_clk;
         end
      end
   end

   function automatic logic [1:0] code_for(input int r);
      case (r)
         16:      return 2'b00;
         32:      return 2'b01;
         128:     return 2'b10;
         default: return 2'b11;
      endcase
   endfunction

   // compare all outputs on every cycle against the model state
   task automatic hold_check(input int cycles, input logic e_act,
                             input logic [1:0] e_code, input logic e_inv,
                             input string tag);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         n_tests++;
         if (ref_active !== e_act || ratio_code !== e_code || ratio_invalid !== e_inv) begin
            n_fail++;
            if (n_print < 10) begin
               n_print++;
               $display("FAIL %s: act/code/inv = %b/%b/%b, expected %b/%b/%b",
                        tag, ref_active, ratio_code, ratio_invalid, e_act, e_code, e_inv);
            end
         end
         n_tests++;
         if (!ref_active && (ratio_code !== 2'b11 || ratio_invalid !== 1'b0)) begin
            n_fail++;
            if (n_print < 10) begin
               n_print++;
               $display("FAIL R9: inactive with code/inv = %b/%b, expected 11/0",
                        ratio_code, ratio_invalid);
            end
         end
      end
   endtask

   task automatic settle(input int windows);
      repeat (windows * WIN) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      hold_check(1, 1'b0, 2'b11, 1'b0, "R1");
      rst_n = 1'b1;
      hold_check(1, 1'b0, 2'b11, 1'b0, "R1");
      hold_check(3 * WIN - 1, 1'b0, 2'b11, 1'b0, "R5");

      ref_ratio = 16;
      settle(6);
      hold_check(2 * WIN, 1'b1, code_for(16), 1'b0, "R2");

      ref_ratio = 32;
      settle(4);
      hold_check(WIN, 1'b1, code_for(32), 1'b0, "R3");
      hold_check(WIN, 1'b1, code_for(32), 1'b0, "R8");

      ref_ratio = 128;
      settle(4);
      hold_check(2 * WIN, 1'b1, code_for(128), 1'b0, "R4");

      ref_ratio = 64;   // count WIN/64 lies between the x128 and x32 bands
      settle(3);
      hold_check(2 * WIN, 1'b1, code_for(128), 1'b1, "R6");

      ref_ratio = 16;
      settle(4);
      hold_check(2 * WIN, 1'b1, code_for(16), 1'b0, "R6");

      // one window at x32 inside a run at x16
      fork
         begin
            ref_ratio = 32;
            repeat (WIN) @(negedge clk);
            ref_ratio = 16;
         end
         hold_check(4 * WIN, 1'b1, code_for(16), 1'b0, "R7");
      join

      ref_ratio = 0;
      settle(3);
      hold_check(2 * WIN, 1'b0, 2'b11, 1'b0, "R5");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run still busy, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule